// File: doc/BRIEF.md
# Bidirectional Bus Transceiver with Parity Generation and Checking

This block links two 8-bit buses, side A and side B, and carries data between them without inversion. A direction input picks the flow. When it is high the block transmits, and side A data is driven onto side B. When it is low the block receives, and side B data is driven onto side A. An active-low enable releases both sides together. Each bidirectional pin is modelled as three signals: an input value, an output value and a drive enable. The pad ring combines them into a real tristate pin.

A single parity pin changes its role with the direction. While transmitting, the block drives this pin with a parity bit computed over side A. While receiving, the pin is an input. The block adds it to the weight of side B and raises an active-low mismatch flag when the nine-bit total is wrong. A sense input chooses between even and odd parity. The logic is purely combinational, and electrical drive, loading and delay are outside this model.

Top module: `parity_xcvr`

## Requirements
- R1: With `dir`=1 and `oe_n`=0, `b_oe` is 1 and `b_out` equals `a_in` bit for bit.
- R2: With `dir`=0 and `oe_n`=0, `a_oe` is 1 and `a_out` equals `b_in` bit for bit.
- R3: With `oe_n`=1, `a_oe`, `b_oe` and `par_oe` are all 0, whatever the other inputs are.
- R4: `a_oe` and `b_oe` are never 1 at the same time.
- R5: When transmitting with `odd_sel`=0, `par_out` is 1 if `a_in` holds an odd number of ones, and 0 if that count is even.
- R6: When transmitting with `odd_sel`=1, `par_out` is the complement of the value given in R5.
- R7: `par_oe` is 1 exactly when `dir`=1 and `oe_n`=0.
- R8: When receiving with `odd_sel`=0, `err_n` is 0 if the nine-bit weight of `b_in` plus `par_in` is odd, and 1 if it is even.
- R9: When receiving with `odd_sel`=1, `err_n` is 0 if the nine-bit weight of `b_in` plus `par_in` is even, and 1 if it is odd.
- R10: `err_n` is 1 whenever `dir`=1 or `oe_n`=1, whatever `b_in` and `par_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | Value observed on side A |
| a_out | output | 8 | Value driven onto side A while receiving |
| a_oe | output | 1 | Drive enable for side A |
| b_in | input | 8 | Value observed on side B |
| b_out | output | 8 | Value driven onto side B while transmitting |
| b_oe | output | 1 | Drive enable for side B |
| par_in | input | 1 | Parity bit observed on the shared parity pin |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Drive enable for the parity pin |
| err_n | output | 1 | Active-low parity mismatch flag |
| dir | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| oe_n | input | 1 | Active-low enable for both sides |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |

## Verification
Every combination of `dir`, `oe_n`, `odd_sel` and `par_in` is applied to each data word in a fixed set and in a pseudo-random stream. The fixed set holds all zeros and all ones, which tell a stuck parity sense apart from a correct one. It holds single set bits at both ends, which show whether a bit is missing from the parity reduction. It holds 0x55 and 0xAA, which expose swapped lanes in the pass-through. It holds words with seven ones, which check odd weights close to the full width. Both sides always carry unrelated values, so any crossed direction shows up as a data miscompare. The error flag is also observed while transmitting and while disabled, to confirm that it stays quiet there.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

    localparam int unsigned BUS_W = 8;

    typedef enum logic {
        FLOW_RX = 1'b0,
        FLOW_TX = 1'b1
    } flow_e;

    typedef struct packed {
        logic a_en;
        logic b_en;
        logic par_en;
        logic rx_check;
    } drive_ctl_t;

endpackage

// File: rtl/parity_xcvr_reduce.sv
module parity_xcvr_reduce #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    output logic             odd_weight
);
    localparam int unsigned STAGES = WIDTH;

    logic [STAGES:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_fold
            assign chain[i+1] = chain[i] ^ din[i];
        end
    endgenerate

    assign odd_weight = chain[STAGES];

endmodule

// File: rtl/parity_xcvr_route.sv
module parity_xcvr_route
    import parity_xcvr_pkg::*;
(
    input  logic       dir,
    input  logic       oe_n,
    output drive_ctl_t ctl
);
    drive_ctl_t ctl_d;

    always_comb begin
        ctl_d          = '0;
        if (!oe_n) begin
            if (flow_e'(dir) == FLOW_TX) begin
                ctl_d.b_en   = 1'b1;
                ctl_d.par_en = 1'b1;
            end else begin
                ctl_d.a_en     = 1'b1;
                ctl_d.rx_check = 1'b1;
            end
        end
    end

    assign ctl = ctl_d;

    always_comb begin
        if (!$isunknown({dir, oe_n})) begin
            AST_PORTS_EXCLUSIVE: assert (!(ctl.a_en && ctl.b_en))
                else $error("both sides driven"); // R4
            AST_PAR_WITH_TX: assert (ctl.par_en == ctl.b_en)
                else $error("parity drive not tied to transmit"); // R7
        end
    end

endmodule

// File: rtl/parity_xcvr_check.sv
module parity_xcvr_check (
    input  logic rx_check,
    input  logic bus_odd,
    input  logic par_bit,
    input  logic odd_sel,
    output logic err_n
);
    logic total_odd;
    logic mismatch;

    always_comb begin
        total_odd = bus_odd ^ par_bit;
        mismatch  = odd_sel ? !total_odd : total_odd;
        err_n     = !(rx_check && mismatch);
    end

    always_comb begin
        if (!$isunknown({rx_check, bus_odd, par_bit, odd_sel})) begin
            AST_QUIET_OUTSIDE_RX: assert (rx_check || err_n)
                else $error("flag raised outside receive"); // R10
        end
    end

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import parity_xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = BUS_W
) (
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             err_n,
    input  logic             dir,
    input  logic             oe_n,
    input  logic             odd_sel
);
    typedef struct packed {
        logic [WIDTH-1:0] a_val;
        logic             a_en;
        logic [WIDTH-1:0] b_val;
        logic             b_en;
        logic             par_val;
        logic             par_en;
    } pins_t;

    drive_ctl_t ctl;
    logic       a_odd;
    logic       b_odd;
    logic       flag_n;
    pins_t      pins_d;

    parity_xcvr_route u_route (
        .dir  (dir),
        .oe_n (oe_n),
        .ctl  (ctl)
    );

    parity_xcvr_reduce #(.WIDTH(WIDTH)) u_reduce_a (
        .din        (a_in),
        .odd_weight (a_odd)
    );

    parity_xcvr_reduce #(.WIDTH(WIDTH)) u_reduce_b (
        .din        (b_in),
        .odd_weight (b_odd)
    );

    parity_xcvr_check u_check (
        .rx_check (ctl.rx_check),
        .bus_odd  (b_odd),
        .par_bit  (par_in),
        .odd_sel  (odd_sel),
        .err_n    (flag_n)
    );

    always_comb begin
        pins_d         = '0;
        pins_d.a_val   = b_in;
        pins_d.a_en    = ctl.a_en;
        pins_d.b_val   = a_in;
        pins_d.b_en    = ctl.b_en;
        pins_d.par_val = a_odd ^ odd_sel;
        pins_d.par_en  = ctl.par_en;
    end

    assign a_out   = pins_d.a_val;
    assign a_oe    = pins_d.a_en;
    assign b_out   = pins_d.b_val;
    assign b_oe    = pins_d.b_en;
    assign par_out = pins_d.par_val;
    assign par_oe  = pins_d.par_en;
    assign err_n   = flag_n;

    always_comb begin
        if (!$isunknown({dir, oe_n, odd_sel, par_in, a_in, b_in})) begin
            AST_DISABLED_RELEASE: assert (!oe_n || (!a_oe && !b_oe && !par_oe))
                else $error("drive while disabled"); // R3
            AST_FLAG_NEEDS_RX: assert (err_n || (!dir && !oe_n))
                else $error("flag outside receive"); // R10
            AST_TX_DIRECTION: assert (!b_oe || (dir && !oe_n))
                else $error("B driven without transmit"); // R1
            AST_RX_DIRECTION: assert (!a_oe || (!dir && !oe_n))
                else $error("A driven without receive"); // R2
        end
    end

endmodule

// File: tb/tb_parity_xcvr.sv
module tb_parity_xcvr;

    localparam int unsigned W = 8;
    localparam int unsigned WATCHDOG = 200000;

    logic         clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         par_in = 1'b0;
    logic         dir = 1'b0;
    logic         oe_n = 1'b1;
    logic         odd_sel = 1'b0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe, b_oe, par_out, par_oe, err_n;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;

    parity_xcvr dut (
        .a_in    (a_in),
        .a_out   (a_out),
        .a_oe    (a_oe),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_oe    (b_oe),
        .par_in  (par_in),
        .par_out (par_out),
        .par_oe  (par_oe),
        .err_n   (err_n),
        .dir     (dir),
        .oe_n    (oe_n),
        .odd_sel (odd_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (dir=%0b oe_n=%0b odd=%0b par_in=%0b a=%0h b=%0h)",
                     tag, act, exp, dir, oe_n, odd_sel, par_in, a_in, b_in);
        end
    endtask

    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic d, input logic en_n, input logic os, input logic pi);
        int   wa;
        int   wt;
        logic exp_par;
        logic exp_err_n;
        @(posedge clk);
        a_in = av; b_in = bv; dir = d; oe_n = en_n; odd_sel = os; par_in = pi;
        @(negedge clk);
        wa = $countones(av);
        wt = $countones(bv) + int'(pi);
        check("R4", {31'd0, a_oe & b_oe}, 32'd0);
        check("R7", {31'd0, par_oe}, {31'd0, d & !en_n});
        if (en_n) begin
            check("R3", {29'd0, a_oe, b_oe, par_oe}, 32'd0);
            check("R10", {31'd0, err_n}, 32'd1);
        end else if (d) begin
            check("R1", {23'd0, b_oe, b_out}, {23'd0, 1'b1, av});
            exp_par = (wa % 2 == 1) ? 1'b1 : 1'b0;
            if (os) check("R6", {31'd0, par_out}, {31'd0, !exp_par});
            else    check("R5", {31'd0, par_out}, {31'd0, exp_par});
            check("R10", {31'd0, err_n}, 32'd1);
        end else begin
            check("R2", {23'd0, a_oe, a_out}, {23'd0, 1'b1, bv});
            if (os) begin
                exp_err_n = (wt % 2 == 1);
                check("R9", {31'd0, err_n}, {31'd0, exp_err_n});
            end else begin
                exp_err_n = (wt % 2 == 0);
                check("R8", {31'd0, err_n}, {31'd0, exp_err_n});
            end
        end
    endtask

    task automatic sweep(input logic [W-1:0] av, input logic [W-1:0] bv);
        for (int c = 0; c < 16; c++) begin
            apply(av, bv, c[0], c[1], c[2], c[3]);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] fixed [10];
        logic [15:0]  lfsr;
        fixed = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'h55, 8'hAA, 8'h7F, 8'hFE, 8'h3C, 8'h96};
        // Reset state: disabled, nothing driven, flag quiet (R3, R10)
        @(negedge clk);
        check("R3", {29'd0, a_oe, b_oe, par_oe}, 32'd0);
        check("R10", {31'd0, err_n}, 32'd1);
        for (int i = 0; i < 10; i++) begin
            sweep(fixed[i], fixed[9 - i]);
            sweep(fixed[i], ~fixed[i]);
        end
        lfsr = 16'hACE1;
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sweep(lfsr[7:0], lfsr[15:8]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule